// File: doc/BRIEF.md
# Parallel Display Transaction Sequencer

This block drives a command/data parallel display bus of the 8080 kind. Software starts a transaction, and the block steps through a fixed order of phases: an optional front blank, a command of one or two cycles, an optional dummy phase, a data phase fed from a valid/ready pixel stream, and an optional back blank. It then returns to idle and pulses a done flag. The block sets the parallel bus and the data/command select line in every cycle.

Each phase cycle takes one pixel-clock enable tick (`tick_en`). Every setting comes in on plain input ports: which phases are on, their lengths, the 32-bit command word, the select-line levels, the bus width (8 or 16 lanes), byte swapping and lane reversal. These settings are copied into a shadow register by an update strobe while the block is idle, and a transaction runs on the shadow copy. A one-cycle clear pulse abandons a transaction at any point.

Top module: `pdisp_seq`

## Requirements
- R1: After an accepted start, phases run in the order front blank, command, dummy, data, back blank, and disabled phases are skipped. Both blanks are present when `blank_on`=1 and last `fblank_len`+1 and `bblank_len`+1 cycles. Dummy lasts `dum_len`+1 cycles and data lasts `dat_len`+1 cycles. A start with no phase enabled goes straight to done.
- R2: The command phase lasts 1 cycle, or 2 when `cmd_dbl`=1. In 16-lane mode the bus carries `cmd_word[15:0]` and then `cmd_word[31:16]`. In 8-lane mode lanes [7:0] carry `cmd_word[7:0]` and then `cmd_word[23:16]`, and lanes [15:8] are 0.
- R3: `dc_out` equals `dc_rest` in idle and in both blanks. During command, dummy and data it equals `dc_rest` XOR `dc_cmd_flip`, `dc_dum_flip` and `dc_dat_flip` respectively.
- R4: In 16-lane mode each data cycle sends one stream word. `swap_bytes`=1 sends `{px_data[7:0], px_data[15:8]}`.
- R5: In 8-lane mode each stream word spans two data cycles on lanes [7:0], low byte first, and lanes [15:8] are 0. `swap_bytes`=1 sends the high byte first. A word is consumed on its second byte, or on its first byte when that is the last data cycle.
- R6: With `rev_bits`=1, lane i carries bit W-1-i of the value the bus would otherwise carry, where W is the active width (16 or 8). This applies to command and data cycles.
- R7: The bus is 0 in idle, blank and dummy cycles, and `px_ready` is 0 outside the data phase.
- R8: With `stream_mode`=0, a data cycle whose stream word is missing waits, and the bus shows 0 while it waits. With `stream_mode`=1 the data phase ignores `dat_len`: it continues while words arrive and ends on the first tick that has none, and that cycle shows bus 0.
- R9: Phase cycles advance only on clock edges where `tick_en`=1.
- R10: `update` copies the settings only while idle. A start without update reuses the previous settings. Start and update while busy are ignored.
- R11: `done` is a one-cycle pulse in the first idle cycle after the last phase, and `busy` is 1 whenever a phase is active.
- R12: A `clr` pulse returns the block to idle on the next cycle with no done pulse.
- R13: After reset the block is idle: bus 0, `dc_out` 0, `busy` 0, `done` 0, `px_ready` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Pixel clock enable; one phase cycle per tick |
| start | input | 1 | Begin a transaction when idle |
| update | input | 1 | Copy settings into the shadow register when idle |
| clr | input | 1 | One-cycle pulse that abandons the transaction |
| cmd_on | input | 1 | Command phase present |
| cmd_dbl | input | 1 | Command phase lasts two cycles |
| cmd_word | input | 32 | Command value |
| dum_on | input | 1 | Dummy phase present |
| dum_len | input | LEN_W | Dummy cycles minus one |
| dat_on | input | 1 | Data phase present |
| dat_len | input | LEN_W | Data cycles minus one |
| stream_mode | input | 1 | Data phase length set by the stream |
| blank_on | input | 1 | Front and back blank present |
| fblank_len | input | BLK_W | Front blank cycles minus one |
| bblank_len | input | BLK_W | Back blank cycles minus one |
| wide_bus | input | 1 | 1: 16 lanes, 0: 8 lanes |
| swap_bytes | input | 1 | Byte order swap for data |
| rev_bits | input | 1 | Reverse lane order |
| dc_rest | input | 1 | Select-line idle level |
| dc_cmd_flip | input | 1 | Invert select line during command |
| dc_dum_flip | input | 1 | Invert select line during dummy |
| dc_dat_flip | input | 1 | Invert select line during data |
| px_data | input | BUS_W | Stream word |
| px_valid | input | 1 | Stream word present |
| px_ready | output | 1 | Stream word taken at this edge (with px_valid) |
| bus_out | output | BUS_W | Parallel bus |
| dc_out | output | 1 | Data/command select line |
| busy | output | 1 | A phase is active |
| done | output | 1 | Transaction finished pulse |

## Verification
The assertions assume a stream that follows valid/ready rules: a word stays on `px_data` until it is taken, and `px_valid` does not depend on `px_ready`. They also assume that `clr` is only a single-cycle pulse. The bench holds its stream word on a counter that advances only on a taken word, and it lowers valid only by limiting how many words are available. Every pulse the bench drives lasts exactly one cycle and is driven at the falling edge.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FBLK  = 3'd1,
    PH_CMD   = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_BBLK  = 3'd5
  } phase_e;

  // First enabled phase strictly after cur in the fixed order, else idle.
  function automatic phase_e next_phase(phase_e cur, logic blk, logic cmd,
                                        logic dum, logic dat);
    logic [5:0] en;
    phase_e     r;
    en = {blk, dat, dum, cmd, blk, 1'b0};
    r  = PH_IDLE;
    for (int i = 5; i >= 1; i--) begin
      if (i > int'(cur) && en[i]) r = phase_e'(3'(i));
    end
    return r;
  endfunction

  // Command cycle count: 0, 1 or 2.
  function automatic int cmd_cycles(logic on, logic dbl);
    return on ? (dbl ? 2 : 1) : 0;
  endfunction

endpackage

// File: rtl/pdisp_shadow.sv
module pdisp_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         busy,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(q));

endmodule

// File: rtl/pdisp_phase_fsm.sv
module pdisp_phase_fsm
  import pdisp_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             tick_en,
  input  logic             blank_on,
  input  logic             cmd_on,
  input  logic             cmd_dbl,
  input  logic             dum_on,
  input  logic             dat_on,
  input  logic             stream_mode,
  input  logic             wide,
  input  logic [BLK_W-1:0] fblank_len,
  input  logic [BLK_W-1:0] bblank_len,
  input  logic [LEN_W-1:0] dum_len,
  input  logic [LEN_W-1:0] dat_len,
  input  logic             px_valid,
  output phase_e           phase,
  output logic             second,
  output logic             half,
  output logic             px_ready,
  output logic             busy,
  output logic             done
);

  localparam int CW = (LEN_W > BLK_W) ? LEN_W : BLK_W;

  logic [CW-1:0] cnt;
  logic          adv;      // a phase cycle completes at this edge
  logic          last;     // current cycle is the final one of the phase
  logic          start_go;
  logic          data_last;
  phase_e        nxt, first;

  assign data_last = !stream_mode && (cnt == CW'(dat_len));

  always_comb begin
    unique case (phase)
      PH_FBLK:  last = (cnt == CW'(fblank_len));
      PH_CMD:   last = (cnt[0] == cmd_dbl);
      PH_DUMMY: last = (cnt == CW'(dum_len));
      PH_DATA:  last = stream_mode ? !px_valid : data_last;
      PH_BBLK:  last = (cnt == CW'(bblank_len));
      default:  last = 1'b0;
    endcase
  end

  assign adv = tick_en && (phase != PH_IDLE) &&
               (phase != PH_DATA || px_valid || stream_mode);
  assign nxt      = next_phase(phase, blank_on, cmd_on, dum_on, dat_on);
  assign first    = next_phase(PH_IDLE, blank_on, cmd_on, dum_on, dat_on);
  assign start_go = start && (phase == PH_IDLE) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
      done  <= 1'b0;
    end else if (clr) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_go) begin
        phase <= first;
        cnt   <= '0;
        half  <= 1'b0;
        done  <= (first == PH_IDLE);
      end else if (adv) begin
        if (last) begin
          phase <= nxt;
          cnt   <= '0;
          half  <= 1'b0;
          done  <= (nxt == PH_IDLE);
        end else begin
          cnt  <= cnt + 1'b1;
          half <= (phase == PH_DATA) ? !half : half;
        end
      end
    end
  end

  assign second   = (cnt != '0);
  assign busy     = (phase != PH_IDLE);
  assign px_ready = (phase == PH_DATA) && tick_en &&
                    (wide || half || data_last);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));

  // R11
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv && !clr) |=> ($stable(phase) && $stable(cnt)));

  // R12
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == PH_IDLE && !done));

  // R2
  cmd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && cnt != '0) |-> (cmd_dbl && cnt == CW'(1)));

endmodule

// File: rtl/pdisp_bus_fmt.sv
module pdisp_bus_fmt
  import pdisp_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase,
  input  logic               second,
  input  logic               half,
  input  logic               wide,
  input  logic               swap,
  input  logic               rev,
  input  logic [2*BUS_W-1:0] cmd_word,
  input  logic [BUS_W-1:0]   px_data,
  input  logic               px_valid,
  input  logic               dc_rest,
  input  logic               dc_cmd_flip,
  input  logic               dc_dum_flip,
  input  logic               dc_dat_flip,
  output logic [BUS_W-1:0]   bus_out,
  output logic               dc_out
);

  localparam int HALF = BUS_W / 2;

  logic [BUS_W-1:0] raw, rev_w, rev_n;
  logic [HALF-1:0]  cmd_b, dat_b;
  logic [BUS_W-1:0] cmd_w, dat_w;

  assign cmd_w = second ? cmd_word[2*BUS_W-1:BUS_W] : cmd_word[BUS_W-1:0];
  assign cmd_b = second ? cmd_word[BUS_W+HALF-1:BUS_W] : cmd_word[HALF-1:0];
  assign dat_w = swap ? {px_data[HALF-1:0], px_data[BUS_W-1:HALF]} : px_data;
  assign dat_b = (half ^ swap) ? px_data[BUS_W-1:HALF] : px_data[HALF-1:0];

  always_comb begin
    raw = '0;
    if (phase == PH_CMD)
      raw = wide ? cmd_w : {{HALF{1'b0}}, cmd_b};
    else if (phase == PH_DATA && px_valid)
      raw = wide ? dat_w : {{HALF{1'b0}}, dat_b};
  end

  for (genvar i = 0; i < BUS_W; i++) begin : g_rev_w
    assign rev_w[i] = raw[BUS_W-1-i];
  end
  for (genvar i = 0; i < HALF; i++) begin : g_rev_n
    assign rev_n[i] = raw[HALF-1-i];
  end
  assign rev_n[BUS_W-1:HALF] = '0;

  assign bus_out = !rev ? raw : (wide ? rev_w : rev_n);

  always_comb begin
    unique case (phase)
      PH_CMD:   dc_out = dc_rest ^ dc_cmd_flip;
      PH_DUMMY: dc_out = dc_rest ^ dc_dum_flip;
      PH_DATA:  dc_out = dc_rest ^ dc_dat_flip;
      default:  dc_out = dc_rest;
    endcase
  end

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_IDLE, PH_FBLK, PH_DUMMY, PH_BBLK}) |-> (bus_out == '0));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (bus_out[BUS_W-1:HALF] == '0));

  // R3
  dc_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_IDLE, PH_FBLK, PH_BBLK}) |-> (dc_out == dc_rest));

endmodule

// File: rtl/pdisp_seq.sv
module pdisp_seq
  import pdisp_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int BLK_W = 8,
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               start,
  input  logic               update,
  input  logic               clr,
  input  logic               cmd_on,
  input  logic               cmd_dbl,
  input  logic [2*BUS_W-1:0] cmd_word,
  input  logic               dum_on,
  input  logic [LEN_W-1:0]   dum_len,
  input  logic               dat_on,
  input  logic [LEN_W-1:0]   dat_len,
  input  logic               stream_mode,
  input  logic               blank_on,
  input  logic [BLK_W-1:0]   fblank_len,
  input  logic [BLK_W-1:0]   bblank_len,
  input  logic               wide_bus,
  input  logic               swap_bytes,
  input  logic               rev_bits,
  input  logic               dc_rest,
  input  logic               dc_cmd_flip,
  input  logic               dc_dum_flip,
  input  logic               dc_dat_flip,
  input  logic [BUS_W-1:0]   px_data,
  input  logic               px_valid,
  output logic               px_ready,
  output logic [BUS_W-1:0]   bus_out,
  output logic               dc_out,
  output logic               busy,
  output logic               done
);

  localparam int CMD_W = 2 * BUS_W;
  localparam int SH_W  = 2 + CMD_W + 2 + 2 * LEN_W + 2 + 2 * BLK_W + 7;

  logic [SH_W-1:0] cfg_in, cfg_q, cfg_use;
  logic            load;

  logic               u_cmd_on, u_cmd_dbl, u_dum_on, u_dat_on, u_stream;
  logic               u_blank_on, u_wide, u_swap, u_rev;
  logic               u_dc_rest, u_dc_c, u_dc_d, u_dc_t;
  logic [CMD_W-1:0]   u_cmd_word;
  logic [LEN_W-1:0]   u_dum_len, u_dat_len;
  logic [BLK_W-1:0]   u_fblk, u_bblk;

  phase_e phase;
  logic   second, half;

  assign cfg_in = {cmd_on, cmd_dbl, cmd_word, dum_on, dum_len, dat_on, dat_len,
                   stream_mode, blank_on, fblank_len, bblank_len, wide_bus,
                   swap_bytes, rev_bits, dc_rest, dc_cmd_flip, dc_dum_flip,
                   dc_dat_flip};

  assign load    = update && !busy;
  assign cfg_use = load ? cfg_in : cfg_q;

  assign {u_cmd_on, u_cmd_dbl, u_cmd_word, u_dum_on, u_dum_len, u_dat_on,
          u_dat_len, u_stream, u_blank_on, u_fblk, u_bblk, u_wide, u_swap,
          u_rev, u_dc_rest, u_dc_c, u_dc_d, u_dc_t} = cfg_use;

  pdisp_shadow #(.W(SH_W)) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .busy (busy),
    .d    (cfg_in),
    .q    (cfg_q)
  );

  pdisp_phase_fsm #(.LEN_W(LEN_W), .BLK_W(BLK_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .start      (start),
    .tick_en    (tick_en),
    .blank_on   (u_blank_on),
    .cmd_on     (u_cmd_on),
    .cmd_dbl    (u_cmd_dbl),
    .dum_on     (u_dum_on),
    .dat_on     (u_dat_on),
    .stream_mode(u_stream),
    .wide       (u_wide),
    .fblank_len (u_fblk),
    .bblank_len (u_bblk),
    .dum_len    (u_dum_len),
    .dat_len    (u_dat_len),
    .px_valid   (px_valid),
    .phase      (phase),
    .second     (second),
    .half       (half),
    .px_ready   (px_ready),
    .busy       (busy),
    .done       (done)
  );

  pdisp_bus_fmt #(.BUS_W(BUS_W)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .second     (second),
    .half       (half),
    .wide       (u_wide),
    .swap       (u_swap),
    .rev        (u_rev),
    .cmd_word   (u_cmd_word),
    .px_data    (px_data),
    .px_valid   (px_valid),
    .dc_rest    (u_dc_rest),
    .dc_cmd_flip(u_dc_c),
    .dc_dum_flip(u_dc_d),
    .dc_dat_flip(u_dc_t),
    .bus_out    (bus_out),
    .dc_out     (dc_out)
  );

endmodule

// File: tb/sim_pdisp_seq.sv
module sim_pdisp_seq;

  typedef struct packed {
    logic        c_on, c_two, d_on;
    logic [3:0]  d_len;
    logic        t_on;
    logic [3:0]  t_len;
    logic        b_on;
    logic [3:0]  f_len, k_len;
    logic        wide, swp, rev, dci, dcc, dcd, dct;
    logic [31:0] word;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,4'd0,1'b1,4'd3,1'b0,4'd0,4'd0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h1234_5678},
    '{1'b1,1'b1,1'b1,4'd1,1'b1,4'd2,1'b1,4'd1,4'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,32'hCAFE_0B0E},
    '{1'b1,1'b1,1'b0,4'd0,1'b1,4'd4,1'b0,4'd0,4'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,32'hAABB_CCDD},
    '{1'b1,1'b0,1'b0,4'd0,1'b1,4'd3,1'b0,4'd0,4'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,32'h0000_00A1},
    '{1'b0,1'b0,1'b1,4'd0,1'b1,4'd1,1'b1,4'd0,4'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,32'h0000_0000},
    '{1'b1,1'b1,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,4'd0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,32'h8001_4003},
    '{1'b0,1'b0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,4'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b1, start = 1'b0, update = 1'b0, clr = 1'b0;
  logic cmd_on, cmd_dbl, dum_on, dat_on, stream_mode, blank_on;
  logic wide_bus, swap_bytes, rev_bits, dc_rest, dc_cmd_flip, dc_dum_flip, dc_dat_flip;
  logic [31:0] cmd_word;
  logic [7:0]  dum_len, dat_len, fblank_len, bblank_len;
  logic [15:0] px_data, bus_out;
  logic        px_valid, px_ready, dc_out, busy, done;

  int   beat_idx = 0, avail = 255;
  logic beat_clr = 1'b0;
  int   total = 0, bad = 0;
  bit   fin = 1'b0;

  logic [15:0] exp_bus [64];
  logic        exp_dc  [64];
  logic [15:0] got_bus [64];
  logic        got_dc  [64];
  logic        got_busy[64];

  always #10 clk = ~clk;

  pdisp_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .update(update),
    .clr(clr), .cmd_on(cmd_on), .cmd_dbl(cmd_dbl), .cmd_word(cmd_word),
    .dum_on(dum_on), .dum_len(dum_len), .dat_on(dat_on), .dat_len(dat_len),
    .stream_mode(stream_mode), .blank_on(blank_on), .fblank_len(fblank_len),
    .bblank_len(bblank_len), .wide_bus(wide_bus), .swap_bytes(swap_bytes),
    .rev_bits(rev_bits), .dc_rest(dc_rest), .dc_cmd_flip(dc_cmd_flip),
    .dc_dum_flip(dc_dum_flip), .dc_dat_flip(dc_dat_flip), .px_data(px_data),
    .px_valid(px_valid), .px_ready(px_ready), .bus_out(bus_out), .dc_out(dc_out),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] w_of(int k);
    return 16'hA5C3 ^ (16'(k) * 16'h1111);
  endfunction

  assign px_data  = w_of(beat_idx);
  assign px_valid = (beat_idx < avail);

  always @(posedge clk) begin
    if (beat_clr) beat_idx <= 0;
    else if (px_ready && px_valid) beat_idx <= beat_idx + 1;
  end

  function automatic logic [15:0] rv16(logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = x[15-i];
    return r;
  endfunction

  function automatic logic [7:0] rv8(logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  // Expected bus value for command cycle c (R2, R6)
  function automatic logic [15:0] cmd_val(vec_t v, int c);
    logic [15:0] w;
    logic [7:0]  b;
    w = (c == 0) ? v.word[15:0] : v.word[31:16];
    b = (c == 0) ? v.word[7:0] : v.word[23:16];
    if (v.wide) return v.rev ? rv16(w) : w;
    return {8'h00, v.rev ? rv8(b) : b};
  endfunction

  // Expected bus value for data cycle j (R4, R5, R6)
  function automatic logic [15:0] dat_val(vec_t v, int j);
    logic [15:0] w;
    logic [7:0]  b;
    if (v.wide) begin
      w = w_of(j);
      if (v.swp) w = {w[7:0], w[15:8]};
      return v.rev ? rv16(w) : w;
    end
    w = w_of(j / 2);
    b = (((j % 2) == 1) ^ v.swp) ? w[15:8] : w[7:0];
    return {8'h00, v.rev ? rv8(b) : b};
  endfunction

  task automatic build_exp(input vec_t v, output int len);
    len = 0;
    if (v.b_on) for (int i = 0; i <= int'(v.f_len); i++) begin
      exp_bus[len] = 16'h0; exp_dc[len] = v.dci; len++;
    end
    if (v.c_on) for (int c = 0; c < (v.c_two ? 2 : 1); c++) begin
      exp_bus[len] = cmd_val(v, c); exp_dc[len] = v.dci ^ v.dcc; len++;
    end
    if (v.d_on) for (int i = 0; i <= int'(v.d_len); i++) begin
      exp_bus[len] = 16'h0; exp_dc[len] = v.dci ^ v.dcd; len++;
    end
    if (v.t_on) for (int j = 0; j <= int'(v.t_len); j++) begin
      exp_bus[len] = dat_val(v, j); exp_dc[len] = v.dci ^ v.dct; len++;
    end
    if (v.b_on) for (int i = 0; i <= int'(v.k_len); i++) begin
      exp_bus[len] = 16'h0; exp_dc[len] = v.dci; len++;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic set_inputs(input vec_t v, input logic alw);
    cmd_on = v.c_on; cmd_dbl = v.c_two; cmd_word = v.word;
    dum_on = v.d_on; dum_len = {4'h0, v.d_len};
    dat_on = v.t_on; dat_len = {4'h0, v.t_len}; stream_mode = alw;
    blank_on = v.b_on; fblank_len = {4'h0, v.f_len}; bblank_len = {4'h0, v.k_len};
    wide_bus = v.wide; swap_bytes = v.swp; rev_bits = v.rev;
    dc_rest = v.dci; dc_cmd_flip = v.dcc; dc_dum_flip = v.dcd; dc_dat_flip = v.dct;
  endtask

  // Starts a transaction and records bus, dc and busy at each falling edge.
  task automatic go(input vec_t v, input bit upd, input logic alw, input int avail0,
                    input int rel_at, input bit slow, input int mid_at,
                    input vec_t mv, input int clr_at, output int nd);
    @(negedge clk);
    set_inputs(v, alw);
    start = 1'b1; update = upd; beat_clr = 1'b1; avail = avail0;
    tick_en = slow ? 1'b0 : 1'b1;
    nd = -1;
    for (int n = 1; n <= 60 && nd < 0; n++) begin
      @(negedge clk);
      got_bus[n-1] = bus_out; got_dc[n-1] = dc_out; got_busy[n-1] = busy;
      if (done) nd = n;
      start = 1'b0; update = 1'b0; clr = 1'b0; beat_clr = 1'b0;
      if (slow) tick_en = ~tick_en;
      if (n == rel_at) avail = 255;
      if (n == mid_at) begin set_inputs(mv, 1'b0); start = 1'b1; update = 1'b1; end
      if (n == clr_at) clr = 1'b1;
    end
    tick_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int   nd, len, miss, first_k, beats;
    vec_t dv;
    set_inputs(VECS[6], 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(bus_out == 16'h0 && !dc_out, "R13 reset bus/dc", {bus_out, 15'h0, dc_out}, 32'h0);
    chk(!busy && !done && !px_ready, "R13 reset flags", {busy, done, px_ready}, 32'h0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      build_exp(VECS[i], len);
      go(VECS[i], 1'b1, 1'b0, 255, -1, 1'b0, -1, VECS[i], -1, nd);
      miss = 0; first_k = 0;
      for (int k = 0; k < len; k++) begin
        if (got_bus[k] !== exp_bus[k] || got_dc[k] !== exp_dc[k]) begin
          if (miss == 0) first_k = k;
          miss++;
        end
      end
      chk(miss == 0, $sformatf("R1 R2 R3 R4 R5 R6 R7 vec%0d cycle%0d bus/dc", i, first_k),
          {got_bus[first_k], 15'h0, got_dc[first_k]},
          {exp_bus[first_k], 15'h0, exp_dc[first_k]});
      chk(nd == len + 1, $sformatf("R11 vec%0d done cycle", i), nd, len + 1);
      if (nd == len + 1)
        chk(got_bus[len] == 16'h0 && got_dc[len] == VECS[i].dci,
            $sformatf("R3 R7 vec%0d idle after done", i),
            {got_bus[len], 15'h0, got_dc[len]}, {16'h0, 15'h0, VECS[i].dci});
      beats = !VECS[i].t_on ? 0 :
              (VECS[i].wide ? int'(VECS[i].t_len) + 1 : (int'(VECS[i].t_len) + 2) / 2);
      chk(beat_idx == beats, $sformatf("R5 R7 vec%0d words taken", i), beat_idx, beats);
    end

    // R8 stall: data only, 4 cycles, two words available, released at n=5
    dv = '{1'b0,1'b0,1'b0,4'd0,1'b1,4'd3,1'b0,4'd0,4'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0};
    go(dv, 1'b1, 1'b0, 2, 5, 1'b0, -1, dv, -1, nd);
    chk(nd == 7, "R8 stall done cycle", nd, 7);
    chk(got_bus[2] == 16'h0, "R8 stall bus zero", got_bus[2], 16'h0);
    chk(beat_idx == 4, "R8 stall words taken", beat_idx, 4);

    // R8 stream mode, 16 lanes, dat_len ignored
    go(dv, 1'b1, 1'b1, 3, -1, 1'b0, -1, dv, -1, nd);
    chk(nd == 5 && beat_idx == 3, "R8 stream-mode wide end", nd * 256 + beat_idx, 5 * 256 + 3);
    chk(got_bus[3] == 16'h0, "R8 stream-mode end cycle bus", got_bus[3], 16'h0);
    dv.wide = 1'b0;
    go(dv, 1'b1, 1'b1, 2, -1, 1'b0, -1, dv, -1, nd);
    chk(nd == 6 && beat_idx == 2, "R8 R5 stream-mode narrow end", nd * 256 + beat_idx, 6 * 256 + 2);

    // R9 tick every other cycle, five phase cycles
    go(VECS[0], 1'b1, 1'b0, 255, -1, 1'b1, -1, VECS[0], -1, nd);
    chk(nd == 10, "R9 slow tick done cycle", nd, 10);

    // R10 start+update while busy ignored
    go(VECS[0], 1'b1, 1'b0, 255, -1, 1'b0, 2, VECS[1], -1, nd);
    chk(nd == 6, "R10 busy start ignored", nd, 6);
    // R10 start without update keeps the previous settings
    go(VECS[1], 1'b0, 1'b0, 255, -1, 1'b0, -1, VECS[1], -1, nd);
    chk(nd == 6, "R10 no update reuses settings", nd, 6);
    chk(got_bus[0] == 16'h5678, "R10 no update command word", got_bus[0], 16'h5678);

    // R12 clear mid transaction
    go(VECS[1], 1'b1, 1'b0, 255, -1, 1'b0, -1, VECS[1], 3, nd);
    chk(got_busy[3] == 1'b0, "R12 clr returns idle", got_busy[3], 0);
    chk(nd == -1, "R12 clr gives no done", nd, -1);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule